// File: doc/BRIEF.md
# Block Framing Tracker for a 128b/130b Receive Path

This block sits on the receive side of a 32-bit parallel path between a serial PHY and a link-layer MAC. It is active only at the 8 GT/s rate, where the line uses 128b/130b encoding. Each cycle it is given one word, its per-byte control bits, a data-valid flag, a block-start flag and a 2-bit sync header. A block payload of 128 bits is four valid words. The tracker counts the position of each valid word within its block. It labels the block as data, ordered set or invalid from the header seen at block start, and passes each accepted word on with its index and block label.

Stall cycles, where data-valid is low, neither move the position nor produce output. Two kinds of framing fault are reported as one-cycle pulses:

- a block start that arrives before the current block is complete;
- a fifth valid word that arrives with no block start.

After reset, or after a framing fault, the tracker drops words until it sees a block start. At the two lower rates the tracker stays idle and drops its lock. All outputs are registered one cycle after the input that caused them.

Top module: `blk_frame_track`

## Requirements
- R1: A word that is accepted appears on `out_data`, with its control bits on `out_ctl`, one cycle after it is presented, and `out_valid` is high for exactly that cycle. Control bit k covers data bits 8k+7:8k.
- R2: The header on a valid block-start cycle sets the block label for all words of that block. Header 2'b10 gives `out_kind` 2'b01 (data) and 2'b01 gives `out_kind` 2'b10 (ordered set). The header is ignored on every other cycle.
- R3: The block-start word has `out_idx` 0. The next valid words of the same block have `out_idx` 1, 2 and 3 in order.
- R4: A cycle with `in_valid` low produces no output, does not advance the position, and has its block-start flag and header ignored.
- R5: On a valid block-start cycle at the 8 GT/s rate, header 2'b00 or 2'b11 raises `hdr_err` for one cycle, one cycle later. If that word is accepted, its block carries `out_kind` 2'b11.
- R6: While locked, a valid block start after fewer than four words of the block, or a valid fifth word with no block start, raises `frame_err` for one cycle, one cycle later. That word is dropped.
- R7: After reset or a framing fault, valid words without block start are dropped. The next valid block start is accepted with `out_idx` 0.
- R8: When `rate_sel` is not 2'b10, no word is output, no error is raised, and the tracker drops its lock.
- R9: After reset, `out_valid`, `hdr_err` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Line rate code; 2'b10 selects 8 GT/s |
| in_data | input | 32 | Received word |
| in_ctl | input | 4 | Per-byte control indicator |
| in_valid | input | 1 | Word valid; low marks a stall |
| in_start | input | 1 | Word is the first of a block |
| in_hdr | input | 2 | Sync header, read on block start |
| out_data | output | 32 | Accepted word |
| out_ctl | output | 4 | Control bits of the accepted word |
| out_idx | output | 2 | Word position in block |
| out_kind | output | 2 | Block label: 01 data, 10 ordered set, 11 invalid |
| out_valid | output | 1 | Output word valid |
| hdr_err | output | 1 | Invalid header pulse |
| frame_err | output | 1 | Framing fault pulse |

## Verification
Some properties are checked by assertions on every cycle:

- an output or a header error always follows a valid input cycle at the 8 GT/s rate;
- index 0 only follows a block start;
- framing faults never come on two cycles in a row.

Other behaviour shows only in the bench's scenarios, where a reference model tracks position and lock:

- the exact index sequence across stalls;
- header sampling only at block start;
- the words dropped after a fault;
- recovery on the next block start.

// File: rtl/blk_frame_pkg.sv
package blk_frame_pkg;
    localparam int DATA_W        = 32;
    localparam int BYTE_W        = 8;
    localparam int CTL_W         = DATA_W / BYTE_W;
    localparam int BLOCK_BITS    = 128;
    localparam int WORDS_PER_BLK = BLOCK_BITS / DATA_W;
    localparam int IDX_W         = $clog2(WORDS_PER_BLK);
    localparam int CNT_W         = $clog2(WORDS_PER_BLK + 1);

    typedef enum logic [1:0] {
        RATE_G1  = 2'b00,
        RATE_G2  = 2'b01,
        RATE_G3  = 2'b10,
        RATE_RSV = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_DATA = 2'b01,
        KIND_OSET = 2'b10,
        KIND_BAD  = 2'b11
    } blk_kind_e;

    localparam logic [1:0] SH_DATA = 2'b10;
    localparam logic [1:0] SH_OSET = 2'b01;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CTL_W-1:0]  ctl;
        logic [IDX_W-1:0]  idx;
        blk_kind_e         kind;
    } word_t;

    function automatic blk_kind_e hdr_to_kind(input logic [1:0] hdr);
        case (hdr)
            SH_DATA: return KIND_DATA;
            SH_OSET: return KIND_OSET;
            default: return KIND_BAD;
        endcase
    endfunction
endpackage

// File: rtl/blk_hdr_decode.sv
module blk_hdr_decode
    import blk_frame_pkg::*;
(
    input  logic [1:0] hdr,
    input  logic       gen3,
    input  logic       vld,
    input  logic       start,
    output blk_kind_e  kind,
    output logic       bad_evt
);
    always_comb begin
        kind    = hdr_to_kind(hdr);
        bad_evt = gen3 && vld && start && (kind == KIND_BAD);
    end
endmodule

// File: rtl/blk_word_counter.sv
module blk_word_counter
    import blk_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             gen3,
    input  logic             vld,
    input  logic             start,
    input  blk_kind_e        kind_in,
    output logic             acc,
    output logic [IDX_W-1:0] acc_idx,
    output blk_kind_e        acc_kind,
    output logic             ferr
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS_PER_BLK);

    logic             locked_q, locked_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    blk_kind_e        kind_q, kind_d;

    always_comb begin
        locked_d = locked_q;
        cnt_d    = cnt_q;
        kind_d   = kind_q;
        acc      = 1'b0;
        acc_idx  = '0;
        acc_kind = kind_q;
        ferr     = 1'b0;
        if (!gen3) begin
            locked_d = 1'b0;
        end else if (vld && start) begin
            if (locked_q && cnt_q != FULL) begin
                ferr     = 1'b1;
                locked_d = 1'b0;
            end else begin
                acc      = 1'b1;
                acc_kind = kind_in;
                kind_d   = kind_in;
                cnt_d    = CNT_W'(1);
                locked_d = 1'b1;
            end
        end else if (vld && locked_q) begin
            if (cnt_q == FULL) begin
                ferr     = 1'b1;
                locked_d = 1'b0;
            end else begin
                acc     = 1'b1;
                acc_idx = cnt_q[IDX_W-1:0];
                cnt_d   = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            cnt_q    <= '0;
            kind_q   <= KIND_NONE;
        end else begin
            locked_q <= locked_d;
            cnt_q    <= cnt_d;
            kind_q   <= kind_d;
        end
    end

    // R3: a word at index 0 is only ever the block-start word
    assert_idx0_on_start_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && !start) |-> (acc_idx != '0));

    // R7: an unlocked tracker accepts only block-start words
    assert_unlocked_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && !locked_q) |-> start);
endmodule

// File: rtl/blk_out_stage.sv
module blk_out_stage
    import blk_frame_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc,
    input  word_t word_in,
    input  logic  hdr_evt,
    input  logic  ferr_evt,
    output word_t word_out,
    output logic  valid_out,
    output logic  hdr_err_out,
    output logic  ferr_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out    <= '0;
            valid_out   <= 1'b0;
            hdr_err_out <= 1'b0;
            ferr_out    <= 1'b0;
        end else begin
            if (acc) word_out <= word_in;
            valid_out   <= acc;
            hdr_err_out <= hdr_evt;
            ferr_out    <= ferr_evt;
        end
    end

    // R6: a fault always drops the lock, so a second fault cannot follow at once
    assert_ferr_single_R6: assert property (@(posedge clk) disable iff (rst)
        ferr_out |=> !ferr_out);

    // R6: the word that caused a fault is dropped
    assert_ferr_no_word_R6: assert property (@(posedge clk) disable iff (rst)
        ferr_out |-> !valid_out);
endmodule

// File: rtl/blk_frame_track.sv
module blk_frame_track
    import blk_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rate_sel,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTL_W-1:0]  in_ctl,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [1:0]        in_hdr,
    output logic [DATA_W-1:0] out_data,
    output logic [CTL_W-1:0]  out_ctl,
    output logic [IDX_W-1:0]  out_idx,
    output logic [1:0]        out_kind,
    output logic              out_valid,
    output logic              hdr_err,
    output logic              frame_err
);
    logic             gen3;
    blk_kind_e        hdr_kind;
    logic             hdr_bad;
    logic             acc;
    logic [IDX_W-1:0] acc_idx;
    blk_kind_e        acc_kind;
    logic             ferr;
    word_t            word_in, word_out;

    assign gen3 = (rate_e'(rate_sel) == RATE_G3);

    blk_hdr_decode u_hdr (
        .hdr     (in_hdr),
        .gen3    (gen3),
        .vld     (in_valid),
        .start   (in_start),
        .kind    (hdr_kind),
        .bad_evt (hdr_bad)
    );

    blk_word_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .gen3     (gen3),
        .vld      (in_valid),
        .start    (in_start),
        .kind_in  (hdr_kind),
        .acc      (acc),
        .acc_idx  (acc_idx),
        .acc_kind (acc_kind),
        .ferr     (ferr)
    );

    always_comb begin
        word_in.data = in_data;
        word_in.ctl  = in_ctl;
        word_in.idx  = acc_idx;
        word_in.kind = acc_kind;
    end

    blk_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .word_in     (word_in),
        .hdr_evt     (hdr_bad),
        .ferr_evt    (ferr),
        .word_out    (word_out),
        .valid_out   (out_valid),
        .hdr_err_out (hdr_err),
        .ferr_out    (frame_err)
    );

    assign out_data = word_out.data;
    assign out_ctl  = word_out.ctl;
    assign out_idx  = word_out.idx;
    assign out_kind = word_out.kind;

    // R4: every output word follows a valid input cycle
    assert_out_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8: outputs and errors only follow cycles at the 8 GT/s rate
    assert_rate_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid || hdr_err || frame_err) |-> ($past(rate_sel) == RATE_G3));

    // R5: a header error only follows a valid block-start cycle
    assert_hdr_err_on_start_R5: assert property (@(posedge clk) disable iff (rst)
        hdr_err |-> $past(in_start && in_valid));

    // R3: an output at index 0 comes from a block-start word
    assert_idx0_from_start_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx == '0) |-> $past(in_start));
endmodule

// File: tb/test_blk_frame_track.sv
module test_blk_frame_track;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rate_sel = 2'b10;
    logic [31:0] in_data = '0;
    logic [3:0]  in_ctl = '0;
    logic        in_valid = 1'b0;
    logic        in_start = 1'b0;
    logic [1:0]  in_hdr = 2'b00;
    logic [31:0] out_data;
    logic [3:0]  out_ctl;
    logic [1:0]  out_idx;
    logic [1:0]  out_kind;
    logic        out_valid, hdr_err, frame_err;

    int n_checks = 0;
    int n_fails  = 0;
    string scen = "INIT";

    bit       m_locked = 0;
    int       m_cnt = 0;
    bit [1:0] m_kind = 2'b00;

    blk_frame_track i_blk_frame_track (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_data(in_data), .in_ctl(in_ctl),
        .in_valid(in_valid), .in_start(in_start), .in_hdr(in_hdr),
        .out_data(out_data), .out_ctl(out_ctl), .out_idx(out_idx), .out_kind(out_kind),
        .out_valid(out_valid), .hdr_err(hdr_err), .frame_err(frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    function automatic bit [1:0] kind_of(input bit [1:0] h);
        if (h == 2'b10) return 2'b01;
        if (h == 2'b01) return 2'b10;
        return 2'b11;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s [%s] act=%0h exp=%0h", tag, scen, act, exp);
        end
    endtask

    task automatic step(input bit [1:0] r, input bit [31:0] d, input bit [3:0] c,
                        input bit v, input bit s, input bit [1:0] h);
        bit e_val, e_hdr, e_ferr;
        bit [1:0] e_idx;
        bit gen3;
        @(negedge clk);
        rate_sel = r; in_data = d; in_ctl = c; in_valid = v; in_start = s; in_hdr = h;
        gen3   = (r == 2'b10);
        e_val  = 0; e_ferr = 0; e_idx = 0;
        e_hdr  = gen3 && v && s && (h == 2'b00 || h == 2'b11);
        if (!gen3) begin
            m_locked = 0;
        end else if (v && s) begin
            if (m_locked && m_cnt != 4) begin
                e_ferr = 1; m_locked = 0;
            end else begin
                e_val = 1; e_idx = 0; m_kind = kind_of(h); m_cnt = 1; m_locked = 1;
            end
        end else if (v && m_locked) begin
            if (m_cnt == 4) begin
                e_ferr = 1; m_locked = 0;
            end else begin
                e_val = 1; e_idx = 2'(m_cnt); m_cnt++;
            end
        end
        @(posedge clk);
        #1;
        check("R1 out_valid", 32'(out_valid), 32'(e_val));
        check("R5 hdr_err", 32'(hdr_err), 32'(e_hdr));
        check("R6 frame_err", 32'(frame_err), 32'(e_ferr));
        if (e_val) begin
            check("R1 out_data", out_data, d);
            check("R1 out_ctl", 32'(out_ctl), 32'(c));
            check("R3 out_idx", 32'(out_idx), 32'(e_idx));
            check("R2 out_kind", 32'(out_kind), 32'(m_kind));
        end
    endtask

    initial begin
        void'($urandom(32'h1234_abcd));
        repeat (3) @(posedge clk);
        #1;
        scen = "R9";
        check("R9 out_valid after reset", 32'(out_valid), 0);
        check("R9 hdr_err after reset", 32'(hdr_err), 0);
        check("R9 frame_err after reset", 32'(frame_err), 0);
        @(negedge clk);
        rst = 1'b0;

        scen = "R7 hunt after reset";
        step(2'b10, 32'h1111_0001, 4'h1, 1, 0, 2'b10);
        step(2'b10, 32'h1111_0002, 4'h2, 1, 0, 2'b10);
        step(2'b10, 32'hA000_0000, 4'h3, 1, 1, 2'b10);
        step(2'b10, 32'hA000_0001, 4'h0, 1, 0, 2'b00);
        step(2'b10, 32'hA000_0002, 4'h0, 1, 0, 2'b11);
        step(2'b10, 32'hA000_0003, 4'h8, 1, 0, 2'b01);

        scen = "R4 stalls mid block";
        step(2'b10, 32'hB000_0000, 4'h0, 1, 1, 2'b01);
        step(2'b10, 32'hDEAD_DEAD, 4'hF, 0, 1, 2'b00);
        step(2'b10, 32'hB000_0001, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hDEAD_DEAD, 4'hF, 0, 0, 2'b11);
        step(2'b10, 32'hB000_0002, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hB000_0003, 4'h4, 1, 0, 2'b10);

        scen = "R5 bad header";
        step(2'b10, 32'hC000_0000, 4'h0, 1, 1, 2'b11);
        step(2'b10, 32'hC000_0001, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hC000_0002, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hC000_0003, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hC100_0000, 4'h0, 1, 1, 2'b00);

        scen = "R6 early start";
        step(2'b10, 32'hD000_0000, 4'h0, 1, 1, 2'b10);
        scen = "R7 drop after fault";
        step(2'b10, 32'hD000_0001, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hD000_0002, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hE000_0000, 4'h1, 1, 1, 2'b10);
        step(2'b10, 32'hE000_0001, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hE000_0002, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hE000_0003, 4'h0, 1, 0, 2'b10);
        scen = "R6 fifth word";
        step(2'b10, 32'hE000_0004, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hE000_0005, 4'h0, 1, 0, 2'b10);

        scen = "R8 lower rate idle";
        step(2'b10, 32'hF000_0000, 4'h0, 1, 1, 2'b10);
        step(2'b00, 32'hF000_0001, 4'h0, 1, 1, 2'b11);
        step(2'b01, 32'hF000_0002, 4'h0, 1, 0, 2'b00);
        step(2'b10, 32'hF000_0003, 4'h0, 1, 0, 2'b10);
        step(2'b10, 32'hF100_0000, 4'h0, 1, 1, 2'b01);

        scen = "RND";
        for (int i = 0; i < 5000; i++) begin
            bit v, s;
            bit [1:0] h, r;
            r = (($urandom % 200) == 0) ? 2'($urandom % 2) : 2'b10;
            v = ($urandom % 4) != 0;
            if (m_locked && m_cnt < 4)       s = ($urandom % 25) == 0;
            else if (m_locked && m_cnt == 4) s = ($urandom % 25) != 0;
            else                             s = ($urandom % 3) != 0;
            if (($urandom % 10) == 0) h = (($urandom % 2) != 0) ? 2'b11 : 2'b00;
            else                      h = (($urandom % 2) != 0) ? 2'b10 : 2'b01;
            step(r, $urandom, 4'($urandom), v, s, h);
        end

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule